// File: doc/BRIEF.md
# Synchronous Serial Master with Bit Clock

This block is a framed serial engine for synchronous operation. On a start request it sends one frame on `tx_o`: a low start bit, the data bits least significant first, then a high stop bit. During the data bits only, it drives a bit clock on `sclk_o` that an external slave can use to shift its own data. The slave returns data on `rx_i`. The block samples that line in the middle of each data bit, at the same instant as the capture edge of the clock, and assembles the received word least significant bit first.

The frame settings are taken at the start request and held for the whole frame: the clock polarity and phase, the word length (8 or 9 bits), whether the last data bit gets a clock pulse, and the prescaler value. A prescaler produces sub-ticks. Sixteen sub-ticks make one bit period. Sub-tick 8 is the middle of a bit and sub-tick 0 is its start. A busy flag covers the frame, and a one-cycle done pulse marks its end.

Top module: `sync_serial_master`

## Requirements
- R1: After reset `tx_o` is 1, `sclk_o` is 0, and `busy_o`, `done_o` and `rx_valid_o` are 0.
- R2: `start_i` high in a clock cycle while idle starts a frame. From the next cycle `busy_o` is 1 and `tx_o` is 0 for one bit period. A bit period is 16*(`presc_i`+1) clock cycles. `presc_i` is latched at the start request.
- R3: The data bits follow the start bit, least significant first, one bit period each. There are 9 data bits (indices 0 to 8) when `long_i` is 1 at the start request, and 8 otherwise. A stop bit at level 1 lasts one bit period.
- R4: Outside the data bits (idle, start bit, stop bit), `sclk_o` stays at the latched polarity level `cpol_i`.
- R5: In each data bit the clock sits at the level opposite to the polarity level for sub-ticks 8 to 15 when `cpha_i`=0, and for sub-ticks 0 to 7 when `cpha_i`=1. Sub-tick k of a bit starts k*(`presc_i`+1) cycles after the bit starts.
- R6: `cpol_i`=1 inverts the whole `sclk_o` waveform compared with `cpol_i`=0.
- R7: When `last_pulse_i` is 0 at the start request, the last data bit produces no clock pulse. `sclk_o` stays at the polarity level for that bit.
- R8: `rx_i` is sampled at the start of sub-tick 8 of each data bit. Data bit i is placed at bit i of `rx_data_o`. `rx_valid_o` pulses for one cycle when the last data bit ends, and `rx_data_o` is valid from that cycle. In 8-bit mode bit 8 of `rx_data_o` is 0.
- R9: `busy_o` falls at the end of the stop bit. In that same cycle `done_o` pulses high for one cycle. A start request while busy is ignored: it does not change the transmitted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request |
| data_i | input | DATA_W | Word to transmit |
| long_i | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cpol_i | input | 1 | Clock polarity (idle level) |
| cpha_i | input | 1 | Clock phase |
| last_pulse_i | input | 1 | 1: emit the clock pulse for the last data bit |
| presc_i | input | DIV_W | Sub-tick length minus one, in clock cycles |
| rx_i | input | 1 | Serial data from the slave |
| tx_o | output | 1 | Serial frame output |
| sclk_o | output | 1 | Bit clock output |
| rx_data_o | output | DATA_W | Received word |
| rx_valid_o | output | 1 | One-cycle pulse when the received word is complete |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
A wrong sub-tick count or bit index shows at the ports within one bit period. It appears as a `tx_o` level in the wrong bit or as a clock edge moved off the middle or the boundary of a bit. The bench samples both outputs at sub-ticks 4 and 12 of every bit. A wrong capture index or length decode shows as a corrupted `rx_data_o`, or as `rx_valid_o` and `done_o` arriving a bit period early or late. Both are checked in the exact cycle they are due.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } ssm_state_e;

  localparam int unsigned SUB_TICKS = 16;
  localparam int unsigned SUB_W     = $clog2(SUB_TICKS);
  localparam int unsigned MID_SUB   = SUB_TICKS / 2;
endpackage

// File: rtl/ssm_prescaler.sv
module ssm_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= div_i);
endmodule

// File: rtl/ssm_clk_shaper.sv
module ssm_clk_shaper
  import ssm_pkg::*;
(
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             in_data_i,
  input  logic             last_bit_i,
  input  logic             last_en_i,
  input  logic [SUB_W-1:0] sub_i,
  output logic             sclk_o
);
  logic second_half;
  logic active;

  assign second_half = sub_i >= SUB_W'(MID_SUB);

  always_comb begin
    active = 1'b0;
    if (in_data_i && !(last_bit_i && !last_en_i))
      active = cpha_i ? !second_half : second_half;
  end

  assign sclk_o = cpol_i ^ active;
endmodule

// File: rtl/ssm_rx_capture.sv
module ssm_rx_capture #(
  parameter int unsigned DATA_W = 9,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              rx_i,
  input  logic              fin_i,
  input  logic              long_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam logic [DATA_W-1:0] SHORT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      if (cap_i) sh_q[idx_i] <= rx_i;
      rx_valid_o <= fin_i;
      if (fin_i) rx_data_o <= long_i ? sh_q : (sh_q & SHORT_MASK);
    end
  end

  // R8
  rx_valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DIV_W  = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              long_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              last_pulse_i,
  input  logic [DIV_W-1:0]  presc_i,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output logic              done_o
);
  ssm_state_e        state_q;
  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic [DIV_W-1:0]  presc_q;
  logic              long_q, cpol_q, cpha_q, last_q;
  logic              tick, bit_end, last_bit, cap, fin;

  assign busy_o   = (state_q != ST_IDLE);
  assign bit_end  = tick && (sub_q == SUB_W'(SUB_TICKS - 1));
  assign last_bit = (idx_q == IDX_W'(long_q ? DATA_W - 1 : DATA_W - 2));
  assign cap      = (state_q == ST_DATA) && tick && (sub_q == SUB_W'(MID_SUB - 1));
  assign fin      = (state_q == ST_DATA) && bit_end && last_bit;

  ssm_prescaler #(.DIV_W(DIV_W)) presc_i0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .div_i  (presc_q),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      presc_q <= '0;
      long_q  <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      last_q  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= (state_q == ST_STOP) && bit_end;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          state_q <= ST_START;
          sub_q   <= '0;
          idx_q   <= '0;
          data_q  <= data_i;
          presc_q <= presc_i;
          long_q  <= long_i;
          cpol_q  <= cpol_i;
          cpha_q  <= cpha_i;
          last_q  <= last_pulse_i;
        end
      end else if (tick) begin
        sub_q <= sub_q + 1'b1;
        if (bit_end) begin
          unique case (state_q)
            ST_START: state_q <= ST_DATA;
            ST_DATA: begin
              if (last_bit) state_q <= ST_STOP;
              else          idx_q   <= idx_q + 1'b1;
            end
            ST_STOP:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = data_q[idx_q];
      default:  tx_o = 1'b1;
    endcase
  end

  ssm_clk_shaper shaper_i0 (
    .cpol_i     (cpol_q),
    .cpha_i     (cpha_q),
    .in_data_i  (state_q == ST_DATA),
    .last_bit_i (last_bit),
    .last_en_i  (last_q),
    .sub_i      (sub_q),
    .sclk_o     (sclk_o)
  );

  ssm_rx_capture #(.DATA_W(DATA_W)) rxcap_i0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .idx_i      (idx_q),
    .rx_i       (rx_i),
    .fin_i      (fin),
    .long_i     (long_q),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );

  // R2
  start_bit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tx_o);

  // R4
  idle_sclk_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(sclk_o));

  // R9
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(data_q));

  // R8
  valid_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> busy_o);
endmodule

// File: tb/sync_serial_master_tb.sv
module sync_serial_master_tb_top;
  localparam int DATA_W = 9;
  localparam int DIV_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, long_s = 1'b0, cpol = 1'b0, cpha = 1'b0, lastp = 1'b1;
  logic rx = 1'b1;
  logic [DATA_W-1:0] data = '0;
  logic [DIV_W-1:0]  presc = '0;
  logic tx, sclk, rx_valid, busy, done;
  logic [DATA_W-1:0] rx_data;

  int checks = 0, errors = 0, cyc = 0, t0 = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sync_serial_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data),
    .long_i(long_s), .cpol_i(cpol), .cpha_i(cpha), .last_pulse_i(lastp),
    .presc_i(presc), .rx_i(rx), .tx_o(tx), .sclk_o(sclk),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0d)", req, act, exp, cyc - t0);
    end
  endtask

  task automatic at(input int c);
    while (cyc - t0 < c) @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx == 1'b1, "R1 tx", tx, 1);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_frame(input logic [8:0] d, input logic [8:0] r, input bit lng,
                           input bit pol, input bit pha, input bit lst,
                           input int p, input bit poke);
    int n, b;
    logic [8:0] exp_rx;
    n = lng ? 9 : 8;
    b = 16 * (p + 1);
    exp_rx = lng ? r : {1'b0, r[7:0]};
    @(negedge clk);
    data = d; long_s = lng; cpol = pol; cpha = pha; lastp = lst;
    presc = DIV_W'(p); start = 1'b1;
    t0 = cyc + 1;
    fork
      begin
        at(0);
        start = 1'b0;
        data = ~d; cpol = ~pol; cpha = ~pha; long_s = ~lng; lastp = ~lst;
        if (poke) begin
          at(3 * b);
          start = 1'b1;
          at(3 * b + 1);
          start = 1'b0;
        end
      end
      begin
        for (int i = 0; i < n; i++) begin
          at((1 + i) * b);
          rx = r[i];
        end
        at((1 + n) * b);
        rx = 1'b1;
      end
      begin
        at(0);
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        for (int j = 0; j <= n; j++) begin
          for (int s = 4; s <= 12; s += 8) begin
            logic etx, esc, act;
            at(j * b + s * (p + 1));
            if (j == 0) begin
              etx = 1'b0; esc = pol;
              chk(tx == etx, "R2 start bit", tx, etx);
              chk(sclk == esc, "R4 no clock in start bit", sclk, esc);
            end else begin
              etx = d[j-1];
              act = pha ? (s < 8) : (s >= 8);
              if (j == n && !lst) act = 1'b0;
              esc = pol ^ act;
              chk(tx == etx, "R3 data bit", tx, etx);
              if (j == n && !lst) chk(sclk == esc, "R7 last pulse suppressed", sclk, esc);
              else if (pol)       chk(sclk == esc, "R6 inverted clock", sclk, esc);
              else                chk(sclk == esc, "R5 clock phase", sclk, esc);
            end
          end
        end
        at((1 + n) * b - 1);
        chk(rx_valid == 1'b0, "R8 valid not early", rx_valid, 0);
        at((1 + n) * b);
        chk(rx_valid == 1'b1, "R8 valid pulse", rx_valid, 1);
        chk(rx_data == exp_rx, "R8 rx data", rx_data, exp_rx);
        at((1 + n) * b + 1);
        chk(rx_valid == 1'b0, "R8 valid one cycle", rx_valid, 0);
        at((1 + n) * b + 4 * (p + 1));
        chk(tx == 1'b1, "R3 stop bit", tx, 1);
        chk(sclk == pol, "R4 no clock in stop bit", sclk, pol);
        at((2 + n) * b - 1);
        chk(busy == 1'b1 && done == 1'b0, "R9 busy through stop", {busy, done}, 2);
        at((2 + n) * b);
        chk(busy == 1'b0 && done == 1'b1, "R9 end of frame", {busy, done}, 1);
        chk(sclk == pol, "R4 idle level", sclk, pol);
        at((2 + n) * b + 1);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
      end
    join
    repeat (3) @(negedge clk);
  endtask

  initial begin
    test_reset();
    run_frame(9'h0a5, 9'h13c, 1'b0, 1'b0, 1'b0, 1'b1, 1, 1'b0); // 8-bit, mode 0
    run_frame(9'h1c3, 9'h1a6, 1'b1, 1'b1, 1'b0, 1'b1, 1, 1'b0); // 9-bit, inverted
    run_frame(9'h05a, 9'h0e1, 1'b0, 1'b0, 1'b1, 1'b0, 1, 1'b0); // phase 1, no last pulse
    run_frame(9'h12d, 9'h052, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b1); // fast, poke while busy
    run_frame(9'h0ff, 9'h1ff, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b1); // slow, 8-bit masks bit 8
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule